// File: doc/BRIEF.md
# Segmented Data Memory Controller

This block serves the data side of a small 8-bit processor core. The core issues 8-bit data addresses, and an 8-bit segment register widens them into a banked space. The lower half of the 8-bit range (0x00–0x7F) is a window that the segment register moves. The upper half (0x80–0xFF) is pinned to base segment 0. That upper half holds sixteen RAM registers and a span that is passed out to memory-mapped peripheral registers. Stack traffic through the stack pointer always lands in segment 0.

The block holds the segment register, the stack pointer, the physical RAM, and the address decode. The decode sorts each access into internal RAM, the external register bus, or an unmapped location. One request port carries reads, writes, pushes and pops. A separate strobe loads the segment register. Physical RAM is sparse. Segment 0 has 112 bytes below 0x70 and the sixteen registers at the top of the base area. Segments 1 to 7 each have a full 128-byte window. Every other location is unmapped.

Top module: `segmem_ctrl`

## Requirements
- R1: For an 8-bit address below 0x80, the access targets physical location {segment, 0, addr[6:0]}. Segments 1 through 7 each hold 128 bytes of RAM that are distinct from each other and from segment 0.
- R2: Addresses 0xF0–0xFF address sixteen RAM bytes that do not depend on the segment register value.
- R3: In segment 0, offsets 0x00–0x6F are RAM and offsets 0x70–0x7F are a hole. A read of the hole returns 0x00. A write to the hole is discarded.
- R4: For segment values 0x08–0xFF, the lower window is unmapped. Reads return 0x00. Writes change no RAM byte.
- R5: Addresses 0x80–0xEF drive the external bus in the same cycle as the request: ext_req=1, ext_we=1 for writes, ext_addr equal to the address, and ext_wdata equal to the write data. The ext_rdata sampled in that cycle is returned as the read result one cycle later.
- R6: After reset, sp_q=0x6F, seg_q=0x00, rd_valid=0 and unmapped=0.
- R7: A push (op 2) writes the data at segment 0, address sp, and then decrements sp. A pop (op 3) increments sp and then reads segment 0 at the new sp. Both ignore and keep the segment register. sp wraps modulo 256.
- R8: The segment register changes only when seg_wr_en is asserted. An access in the same cycle as a segment write uses the old segment.
- R9: A read (op 0) or pop raises rd_valid for exactly the one cycle after the request, with rd_data valid in that cycle. No other request raises rd_valid.
- R10: An access to an unmapped location raises unmapped for exactly the one cycle after the request. Mapped accesses leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Data request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 push, 3 pop |
| req_addr | input | 8 | 8-bit data address (ignored for push and pop) |
| req_wdata | input | 8 | Write or push data |
| seg_wr_en | input | 1 | Load the segment register |
| seg_wr_data | input | 8 | New segment value |
| ext_rdata | input | 8 | Read data from the external register bus |
| ext_req | output | 1 | External register bus access this cycle |
| ext_we | output | 1 | External access is a write |
| ext_addr | output | 8 | External register address |
| ext_wdata | output | 8 | External write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| unmapped | output | 1 | The previous request hit no storage |
| seg_q | output | 8 | Current segment register |
| sp_q | output | 8 | Current stack pointer |

## Verification
The external bus outputs are combinational and belong to the cycle of the request, so the bench samples them 1 ns after it drives the inputs, before the clock edge. Everything else comes one edge after the request: read data, rd_valid, unmapped, the RAM update, and the new segment and stack pointer values. The bench samples these 1 ns after the posedge that accepts the request. It then idles one more cycle to confirm that rd_valid and unmapped fall again. The same-cycle segment-write test relies on this timing: the read issued together with the segment write must return data from the old segment.

// File: rtl/segmem_pkg.sv
package segmem_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int WIN_BITS = ADDR_W - 1;                 // offset bits inside a window
  localparam int WIN_SIZE = 1 << WIN_BITS;              // 128
  localparam logic [7:0] HIGH_SEGS = 8'd7;              // segments 1..HIGH_SEGS carry RAM
  localparam logic [7:0] LOW_TOP   = 8'h6F;             // last RAM byte of segment 0
  localparam logic [7:0] REG_BASE  = 8'hF0;             // first upper RAM register
  localparam int RAM_DEPTH = WIN_SIZE * (int'(HIGH_SEGS) + 1);
  localparam int IDX_W     = $clog2(RAM_DEPTH);
  localparam logic [7:0] SP_RESET  = 8'h6F;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_PUSH = 2'd2, OP_POP = 2'd3} op_e;
  typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_RAM = 2'd1, TGT_EXT = 2'd2} tgt_e;

  typedef struct packed {
    tgt_e             tgt;
    logic [IDX_W-1:0] idx;
  } dec_t;

  // Map a (segment, 8-bit address) pair onto the packed RAM index space:
  // 0..111 segment-0 low RAM, 112..127 upper registers, 128*k+off for k=1..7.
  function automatic dec_t map_addr(input logic [7:0] seg, input logic [7:0] a);
    dec_t d;
    d.tgt = TGT_NONE;
    d.idx = '0;
    if (a[7]) begin
      if (a >= REG_BASE) begin
        d.tgt = TGT_RAM;
        d.idx = IDX_W'(LOW_TOP) + IDX_W'(1) + IDX_W'(a[3:0]);
      end else begin
        d.tgt = TGT_EXT;
      end
    end else if (seg == 8'd0) begin
      if (a <= LOW_TOP) begin
        d.tgt = TGT_RAM;
        d.idx = IDX_W'(a);
      end
    end else if (seg <= HIGH_SEGS) begin
      d.tgt = TGT_RAM;
      d.idx = IDX_W'({seg, a[WIN_BITS-1:0]});
    end
    return d;
  endfunction

  function automatic logic [7:0] sp_after_push(input logic [7:0] sp);
    return sp - 8'd1;
  endfunction

  function automatic logic [7:0] sp_after_pop(input logic [7:0] sp);
    return sp + 8'd1;
  endfunction
endpackage

// File: rtl/segmem_decode.sv
module segmem_decode
  import segmem_pkg::*;
(
  input  logic [7:0] seg,
  input  logic [7:0] addr,
  output dec_t       dec
);
  always_comb dec = map_addr(seg, addr);
endmodule

// File: rtl/segmem_stack.sv
module segmem_stack
  import segmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  output logic [7:0] sp_q,
  output logic [7:0] stk_addr
);
  // push uses the current pointer, pop uses the pre-incremented one
  always_comb stk_addr = pop ? sp_after_pop(sp_q) : sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sp_q <= SP_RESET;
    else if (push) sp_q <= sp_after_push(sp_q);
    else if (pop)  sp_q <= sp_after_pop(sp_q);
  end
endmodule

// File: rtl/segmem_ram.sv
module segmem_ram #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/segmem_ctrl.sv
module segmem_ctrl
  import segmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic       seg_wr_en,
  input  logic [7:0] seg_wr_data,
  input  logic [7:0] ext_rdata,
  output logic       ext_req,
  output logic       ext_we,
  output logic [7:0] ext_addr,
  output logic [7:0] ext_wdata,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       unmapped,
  output logic [7:0] seg_q,
  output logic [7:0] sp_q
);
  op_e        op;
  logic       push_go, pop_go, stack_go;
  logic       want_wr, want_rd;
  logic [7:0] stk_addr, eff_seg, eff_addr;
  dec_t       dec;
  logic       ram_we, ram_re, miss_now;
  logic [7:0] ram_q, ext_q;
  tgt_e       src_q;

  always_comb begin
    op       = op_e'(req_op);
    push_go  = req_valid && (op == OP_PUSH);
    pop_go   = req_valid && (op == OP_POP);
    stack_go = push_go || pop_go;
    want_wr  = req_valid && (op == OP_WRITE || op == OP_PUSH);
    want_rd  = req_valid && (op == OP_READ  || op == OP_POP);
    eff_seg  = stack_go ? 8'd0 : seg_q;
    eff_addr = stack_go ? stk_addr : req_addr;
  end

  segmem_stack u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_go),
    .pop      (pop_go),
    .sp_q     (sp_q),
    .stk_addr (stk_addr)
  );

  segmem_decode u_dec (
    .seg  (eff_seg),
    .addr (eff_addr),
    .dec  (dec)
  );

  always_comb begin
    ram_we    = want_wr && (dec.tgt == TGT_RAM);
    ram_re    = want_rd && (dec.tgt == TGT_RAM);
    miss_now  = req_valid && (dec.tgt == TGT_NONE);
    ext_req   = req_valid && (dec.tgt == TGT_EXT);
    ext_we    = ext_req && want_wr;
    ext_addr  = eff_addr;
    ext_wdata = req_wdata;
  end

  segmem_ram #(.DEPTH(RAM_DEPTH), .AW(IDX_W), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .idx   (dec.idx),
    .wdata (req_wdata),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q    <= 8'd0;
      rd_valid <= 1'b0;
      unmapped <= 1'b0;
      src_q    <= TGT_NONE;
      ext_q    <= 8'd0;
    end else begin
      if (seg_wr_en) seg_q <= seg_wr_data;
      rd_valid <= want_rd;
      unmapped <= miss_now;
      src_q    <= dec.tgt;
      ext_q    <= ext_rdata;
    end
  end

  always_comb begin
    rd_data = 8'd0;
    if (rd_valid) begin
      if (src_q == TGT_RAM)      rd_data = ram_q;
      else if (src_q == TGT_EXT) rd_data = ext_q;
    end
  end
endmodule

// File: rtl/segmem_ctrl_chk.sv
module segmem_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       seg_wr_en,
  input logic [7:0] seg_wr_data,
  input logic       ext_req,
  input logic [7:0] ext_addr,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       unmapped,
  input logic       miss_now,
  input logic [7:0] seg_q,
  input logic [7:0] sp_q
);
  // R9: reads and pops produce a result exactly one cycle later
  p_read_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 2'd0 || req_op == 2'd3)) |=> rd_valid);
  p_no_spurious_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && (req_op == 2'd0 || req_op == 2'd3)) |=> !rd_valid);
  // R3 / R4: an unmapped read returns zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && unmapped) |-> (rd_data == 8'd0));
  // R10: the flag follows a miss by one cycle
  p_unmapped_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_now |=> unmapped);
  p_unmapped_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !unmapped);
  // R8: the segment register only moves on an explicit write
  p_seg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_wr_en |=> $stable(seg_q));
  p_seg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_en |=> (seg_q == $past(seg_wr_data)));
  // R7: stack pointer steps
  p_push_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2) |=> (sp_q == $past(sp_q) - 8'd1));
  p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |=> (sp_q == $past(sp_q) + 8'd1));
  // R5: external bus only sees the peripheral span
  p_ext_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (ext_addr >= 8'h80 && ext_addr <= 8'hEF));
endmodule

bind segmem_ctrl segmem_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .seg_wr_en   (seg_wr_en),
  .seg_wr_data (seg_wr_data),
  .ext_req     (ext_req),
  .ext_addr    (ext_addr),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .unmapped    (unmapped),
  .miss_now    (miss_now),
  .seg_q       (seg_q),
  .sp_q        (sp_q)
);

// File: tb/segmem_ctrl_test.sv
`timescale 1ns/1ps
module segmem_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_addr = 8'd0;
  logic [7:0] req_wdata = 8'd0;
  logic       seg_wr_en = 1'b0;
  logic [7:0] seg_wr_data = 8'd0;
  logic [7:0] ext_rdata;
  logic       ext_req, ext_we, rd_valid, unmapped;
  logic [7:0] ext_addr, ext_wdata, rd_data, seg_q, sp_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic       c_rv, c_um, c_ereq, c_ewe;
  logic [7:0] c_rd, c_eaddr, c_ewd;

  always #2.5 clk = ~clk;
  assign ext_rdata = ext_addr ^ 8'h5A;   // peripheral model

  segmem_ctrl uut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] k, input logic [7:0] a, input logic [7:0] d,
                    input logic sw = 1'b0, input logic [7:0] sd = 8'd0);
    @(negedge clk);
    req_valid = 1'b1; req_op = k; req_addr = a; req_wdata = d;
    seg_wr_en = sw; seg_wr_data = sd;
    #1;
    c_ereq = ext_req; c_ewe = ext_we; c_eaddr = ext_addr; c_ewd = ext_wdata;
    @(posedge clk); #1;
    c_rv = rd_valid; c_rd = rd_data; c_um = unmapped;
    req_valid = 1'b0; seg_wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); @(posedge clk); #1;
    c_rv = rd_valid; c_um = unmapped;
  endtask

  task automatic setseg(input logic [7:0] v);
    @(negedge clk); seg_wr_en = 1'b1; seg_wr_data = v;
    @(posedge clk); #1; seg_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R6 sp", sp_q, 8'h6F);
    chk("R6 seg", seg_q, 8'h00);
    chk("R6 rd_valid", rd_valid, 1'b0);
    chk("R6 unmapped", unmapped, 1'b0);
  endtask

  task automatic t_base_lower();
    op(2'd1, 8'h00, 8'h3A); chk("R3 write 0x00 mapped", c_um, 1'b0);
    op(2'd1, 8'h6F, 8'h4B);
    op(2'd0, 8'h00, 8'h00); chk("R9 rd_valid", c_rv, 1'b1); chk("R3 read 0x00", c_rd, 8'h3A);
    idle(); chk("R9 single-cycle valid", c_rv, 1'b0);
    op(2'd0, 8'h6F, 8'h00); chk("R3 read 0x6F", c_rd, 8'h4B); chk("R10 mapped no flag", c_um, 1'b0);
  endtask

  task automatic t_segments();
    setseg(8'h01); chk("R8 seg load", seg_q, 8'h01);
    op(2'd1, 8'h20, 8'hA1);
    setseg(8'h07); op(2'd1, 8'h20, 8'hC7);
    setseg(8'h00); op(2'd1, 8'h20, 8'h50);
    setseg(8'h01); op(2'd0, 8'h20, 8'h00); chk("R1 seg1 0x20", c_rd, 8'hA1);
    setseg(8'h07); op(2'd0, 8'h20, 8'h00); chk("R1 seg7 0x20", c_rd, 8'hC7);
    setseg(8'h00); op(2'd0, 8'h20, 8'h00); chk("R1 seg0 0x20", c_rd, 8'h50);
  endtask

  task automatic t_upper();
    setseg(8'h03); op(2'd1, 8'hF5, 8'h77); op(2'd1, 8'hFF, 8'h88);
    setseg(8'h00); op(2'd0, 8'hF5, 8'h00); chk("R2 0xF5 seg-free", c_rd, 8'h77);
    setseg(8'h09); op(2'd0, 8'hFF, 8'h00); chk("R2 0xFF seg-free", c_rd, 8'h88);
    chk("R2 not unmapped", c_um, 1'b0);
    op(2'd0, 8'hF0, 8'h00); chk("R5 0xF0 is RAM not ext", c_ereq, 1'b0);
    setseg(8'h00);
  endtask

  task automatic t_hole();
    op(2'd1, 8'h75, 8'h99); chk("R10 hole write flag", c_um, 1'b1);
    idle(); chk("R10 flag one cycle", c_um, 1'b0);
    op(2'd0, 8'h75, 8'h00); chk("R3 hole reads zero", c_rd, 8'h00);
    chk("R3 hole read valid", c_rv, 1'b1); chk("R10 hole read flag", c_um, 1'b1);
    op(2'd0, 8'h70, 8'h00); chk("R3 0x70 unmapped", c_um, 1'b1);
    op(2'd0, 8'h6F, 8'h00); chk("R3 0x6F intact", c_rd, 8'h4B);
  endtask

  task automatic t_high_seg();
    setseg(8'h08);
    op(2'd1, 8'h20, 8'hEE); chk("R4 seg8 write flag", c_um, 1'b1);
    op(2'd0, 8'h20, 8'h00); chk("R4 seg8 read zero", c_rd, 8'h00); chk("R4 seg8 flag", c_um, 1'b1);
    setseg(8'hFF);
    op(2'd0, 8'h00, 8'h00); chk("R4 segFF flag", c_um, 1'b1);
    setseg(8'h00); op(2'd0, 8'h20, 8'h00); chk("R4 seg0 untouched", c_rd, 8'h50);
    setseg(8'h01); op(2'd0, 8'h20, 8'h00); chk("R4 seg1 untouched", c_rd, 8'hA1);
    setseg(8'h00);
  endtask

  task automatic t_ext();
    setseg(8'h04);
    op(2'd0, 8'h85, 8'h00);
    chk("R5 ext_req read", c_ereq, 1'b1); chk("R5 ext_we read", c_ewe, 1'b0);
    chk("R5 ext_addr", c_eaddr, 8'h85); chk("R5 read data", c_rd, 8'h85 ^ 8'h5A);
    op(2'd1, 8'hA0, 8'h3C);
    chk("R5 ext_we write", c_ewe, 1'b1); chk("R5 ext_wdata", c_ewd, 8'h3C);
    op(2'd0, 8'hEF, 8'h00); chk("R5 0xEF ext", c_ereq, 1'b1); chk("R5 0xEF data", c_rd, 8'hEF ^ 8'h5A);
    op(2'd0, 8'h10, 8'h00); chk("R5 lower not ext", c_ereq, 1'b0);
    op(2'd1, 8'h10, 8'h00); chk("R9 write no rd_valid", c_rv, 1'b0);
    setseg(8'h00);
  endtask

  task automatic t_seg_race();
    setseg(8'h01);
    op(2'd0, 8'h20, 8'h00, 1'b1, 8'h07);
    chk("R8 same-cycle old seg data", c_rd, 8'hA1); chk("R8 new seg after", seg_q, 8'h07);
    op(2'd0, 8'h20, 8'h00); chk("R8 new seg used", c_rd, 8'hC7);
    idle(); chk("R8 seg held", seg_q, 8'h07);
    setseg(8'h00);
  endtask

  task automatic t_stack();
    do_reset();
    setseg(8'h05);
    op(2'd2, 8'h00, 8'h11); chk("R7 push dec", sp_q, 8'h6E);
    op(2'd2, 8'h00, 8'h22); chk("R7 push dec 2", sp_q, 8'h6D); chk("R7 seg kept", seg_q, 8'h05);
    op(2'd3, 8'h00, 8'h00); chk("R7 pop data", c_rd, 8'h22); chk("R7 pop inc", sp_q, 8'h6E);
    chk("R9 pop valid", c_rv, 1'b1);
    setseg(8'h00);
    op(2'd0, 8'h6F, 8'h00); chk("R7 push landed seg0", c_rd, 8'h11);
    op(2'd3, 8'h00, 8'h00); chk("R7 pop 2", c_rd, 8'h11); chk("R7 sp back", sp_q, 8'h6F);
    for (int i = 0; i < 112; i++) op(2'd2, 8'h00, 8'(i));
    chk("R7 sp wraps", sp_q, 8'hFF);
    op(2'd3, 8'h00, 8'h00); chk("R7 pop wrap sp", sp_q, 8'h00); chk("R7 pop wrap data", c_rd, 8'h6F);
    op(2'd3, 8'h00, 8'h00); chk("R7 pop next", c_rd, 8'h6E);
  endtask

  initial begin
    t_reset();
    t_base_lower();
    t_segments();
    t_upper();
    t_hole();
    t_high_seg();
    t_ext();
    t_seg_race();
    t_stack();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule